// File: doc/BRIEF.md
# Shared-Adder Integer ALU

This block is the integer arithmetic-logic unit of a small 32-bit processor datapath. It takes two operands and a 3-bit operation select. It returns a result word and a flag that is high when that result is all zeros. The datapath uses the flag for equality tests on branches.

Addition and subtraction share one ripple chain of full adders. Each bit of the second operand first passes through an XOR gate. The subtract control drives both that gate and the carry into the lowest adder. The subtract case therefore forms the two's complement negation of the second operand, and needs no separate incrementer.

The bitwise operations are computed one bit at a time. The two shift operations move the first operand by exactly one bit position: each result bit is taken from the neighbouring bit. The result and the flag are registered. Both appear one clock after the inputs are sampled, and a synchronous active-high reset clears them.

Top module: `shared_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes 0 and `zero` becomes 1, whatever the other inputs are.
- R2: With `op` = 3'd0 (add), `result` equals (`a` + `b`) modulo 2^W at the first rising edge where the inputs are sampled with `rst` low.
- R3: With `op` = 3'd1 (subtract), `result` equals (`a` - `b`) modulo 2^W, computed as `a` + ~`b` + 1 in two's complement.
- R4: With `op` = 3'd2, 3'd3 and 3'd4, `result` is the bitwise AND, OR and XOR of `a` and `b` respectively.
- R5: With `op` = 3'd5 (shift left), `result` bit i equals `a` bit i-1 for i >= 1, and `result` bit 0 is 0; `b` has no effect.
- R6: With `op` = 3'd6 (shift right), `result` bit i equals `a` bit i+1 for i <= W-2, and `result` bit W-1 is 0; `b` has no effect.
- R7: With `op` = 3'd7, `result` is 0 and `zero` is 1 for any operands.
- R8: `zero` is 1 exactly when all W bits of `result` are 0; it changes at the same edge as `result`.
- R9: `result` and `zero` are registered: they reflect the inputs sampled at the previous rising edge and stay unchanged between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a | input | W (32) | First operand; the operand that is shifted |
| b | input | W (32) | Second operand |
| op | input | 3 | Operation select: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 shift right, 7 zero |
| result | output | W (32) | Registered result |
| zero | output | 1 | Registered flag, high when `result` is all zeros |

## Verification
The only state in this block is the output register. A fault inside it shows at the ports one clock after the inputs that exposed it. A broken link in the carry chain, or a wrong polarity on the inverter, shows as a wrong sum or difference only when a carry has to cross that bit. The random operands are therefore mixed with directed cases that ripple across the whole word, such as all-ones plus one and zero minus one. A misrouted shift neighbour, or a wrong fill bit, shows at the edge bits. Directed patterns set the MSB for the left shift and the LSB for the right shift, so that a mistake there is visible in the next cycle's result and zero flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_SHL  = 3'd5,
    ALU_SHR  = 3'd6,
    ALU_NONE = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2
  } bw_sel_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum
);

  // Conditionally inverted second operand and internal carries.
  logic [W-1:0] y_inv;
  logic [W-1:0] carry;

  // The subtract control is the carry into bit 0, which supplies the +1.
  assign carry[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_inv[i] = y[i] ^ sub;
    assign sum[i]   = x[i] ^ y_inv[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (x[i] & y_inv[i]) | (carry[i] & (x[i] ^ y_inv[i]));
    end
  end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]     x,
  input  logic [W-1:0]     y,
  input  alu_pkg::bw_sel_e sel,
  output logic [W-1:0]     q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        alu_pkg::BW_AND: q[i] = x[i] & y[i];
        alu_pkg::BW_OR:  q[i] = x[i] | y[i];
        alu_pkg::BW_XOR: q[i] = x[i] ^ y[i];
        default:         q[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] left,
  output logic [W-1:0] right
);

  // Each output bit takes the neighbour bit; the vacated edge bit is zero.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign left[i] = 1'b0;
    end else begin : g_lo_n
      assign left[i] = x[i-1];
    end
    if (i == W - 1) begin : g_hi
      assign right[i] = 1'b0;
    end else begin : g_hi_n
      assign right[i] = x[i+1];
    end
  end

endmodule

// File: rtl/shared_alu.sv
module shared_alu #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] result,
  output logic         zero
);
  import alu_pkg::*;

  alu_op_e  op_e;
  logic     do_sub;
  bw_sel_e  bw_sel;
  logic [W-1:0] arith_q;
  logic [W-1:0] bw_q;
  logic [W-1:0] shl_q;
  logic [W-1:0] shr_q;
  logic [W-1:0] next_q;

  assign op_e   = alu_op_e'(op);
  assign do_sub = (op_e == ALU_SUB);

  always_comb begin
    unique case (op_e)
      ALU_OR:  bw_sel = BW_OR;
      ALU_XOR: bw_sel = BW_XOR;
      default: bw_sel = BW_AND;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .x   (a),
    .y   (b),
    .sub (do_sub),
    .sum (arith_q)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .x   (a),
    .y   (b),
    .sel (bw_sel),
    .q   (bw_q)
  );

  alu_shift1 #(.W(W)) u_shift (
    .x     (a),
    .left  (shl_q),
    .right (shr_q)
  );

  always_comb begin
    unique case (op_e)
      ALU_ADD, ALU_SUB:         next_q = arith_q;
      ALU_AND, ALU_OR, ALU_XOR: next_q = bw_q;
      ALU_SHL:                  next_q = shl_q;
      ALU_SHR:                  next_q = shr_q;
      default:                  next_q = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b1;
    end else begin
      result <= next_q;
      zero   <= (next_q == '0);
    end
  end

  // High once the output register holds a value computed from sampled inputs.
  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (result == '0 && zero));

  a_r2_add: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op) == 3'd0) |-> result == $past(a) + $past(b));

  a_r3_sub: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op) == 3'd1) |-> result == $past(a) - $past(b));

  a_r5_shl_fill: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op) == 3'd5) |-> (result[0] == 1'b0 && result[W-1:1] == $past(a[W-2:0])));

  a_r6_shr_fill: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op) == 3'd6) |-> (result[W-1] == 1'b0 && result[W-2:0] == $past(a[W-1:1])));

  a_r7_none: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op) == 3'd7) |-> (result == '0 && zero));

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
    primed |-> (zero == (result == '0)));

endmodule

// File: tb/sim_shared_alu.sv
`timescale 1ns/1ps
module sim_shared_alu;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   op = 3'd0;
  logic [W-1:0] result;
  logic         zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  shared_alu #(.W(W)) u0 (
    .clk(clk), .rst(rst), .a(a), .b(b), .op(op),
    .result(result), .zero(zero)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] o);
    case (o)
      3'd0: return x + y;
      3'd1: return x - y;
      3'd2: return x & y;
      3'd3: return x | y;
      3'd4: return x ^ y;
      3'd5: return {x[W-2:0], 1'b0};
      3'd6: return {1'b0, x[W-1:1]};
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3, 3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] o);
    logic [W-1:0] e;
    a = x; b = y; op = o;
    e = model(x, y, o);
    @(posedge clk);
    @(negedge clk);
    chk(req_of(o), result, e);
    chk("R8", {31'd0, zero}, {31'd0, (e == '0)});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] held;
    void'($urandom(32'd20240611));
    @(negedge clk);
    a = 32'hDEAD_BEEF; b = 32'h1234_5678; op = 3'd0;
    @(posedge clk); @(negedge clk);
    // R1: reset clears result and sets zero despite nonzero inputs
    chk("R1", result, '0);
    chk("R1", {31'd0, zero}, 32'd1);
    rst = 1'b0;

    // Carry ripple across the full word
    apply(32'hFFFF_FFFF, 32'h0000_0001, 3'd0);   // R2 wraps to zero
    apply(32'h7FFF_FFFF, 32'h0000_0001, 3'd0);   // R2
    apply(32'h0000_0000, 32'h0000_0001, 3'd1);   // R3 -> all ones
    apply(32'h1234_5678, 32'h1234_5678, 3'd1);   // R3 equal operands, zero set
    apply(32'h8000_0000, 32'h0000_0001, 3'd1);   // R3
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd2);   // R4 AND
    apply(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd3);   // R4 OR
    apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 3'd4);   // R4 XOR -> zero
    apply(32'h8000_0001, 32'h0000_0000, 3'd5);   // R5 MSB drops out
    apply(32'h8000_0001, 32'h0000_0000, 3'd6);   // R6 LSB drops out
    apply(32'h8000_0000, 32'hFFFF_FFFF, 3'd5);   // R5 shifted to zero
    apply(32'hFFFF_FFFF, 32'h1234_5678, 3'd7);   // R7

    // R5/R6: b has no effect on shifts
    apply(32'h3C3C_1234, 32'h0000_0000, 3'd5);
    held = result;
    apply(32'h3C3C_1234, 32'hFFFF_FFFF, 3'd5);
    chk("R5", result, held);
    apply(32'h3C3C_1234, 32'h0000_0000, 3'd6);
    held = result;
    apply(32'h3C3C_1234, 32'h5A5A_5A5A, 3'd6);
    chk("R6", result, held);

    // R9: output holds between edges
    apply(32'h0000_0010, 32'h0000_0020, 3'd0);
    a = 32'h1111_1111; b = 32'h2222_2222; op = 3'd1;
    #2;
    chk("R9", result, 32'h0000_0030);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", result, '0);
    chk("R1", {31'd0, zero}, 32'd1);
    rst = 1'b0;

    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x, y;
      logic [2:0] o;
      x = $urandom();
      y = $urandom();
      o = 3'($urandom_range(0, 7));
      if (n % 16 == 0) y = x;
      apply(x, y, o);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule